// File: doc/BRIEF.md
# Hidden Address-Latch Tracker

This block follows the undocumented 16-bit internal address latch of an 8-bit accumulator-style CPU core. It also reproduces the two hidden flag bits that a bit-test instruction leaks from that latch. The core presents a single-cycle retire strobe for each completed instruction. With it come the instruction's optional prefix byte, its main opcode byte, an index-form indication, the effective memory address, the accumulator value before any write, the operand byte and the number of clock states the instruction took. From these the tracker updates its latch copy and produces the zero, bit-5 and bit-3 flag values of bit tests. It also flags a store whose clock-state count is not the one its form requires.

A run-time select input picks a clone-chip variant. In that variant the accumulator stores write zero into the latch high byte instead of the accumulator.

Top module: `addr_latch_tracker`

## Requirements
- R1: While reset is asserted, and after it is released until the first retire, `latch_q` reads 0x0000 and `bit_zero`, `bit_f5`, `bit_f3` and `len_err` read 0.
- R2: An unprefixed accumulator store (opcode 0x02, 0x12 or 0x32) with `clone_mode` low sets `latch_q[7:0]` to (address+1) modulo 256 and `latch_q[15:8]` to `retire_acc`. No carry passes from the low byte into the high byte.
- R3: The same accumulator stores with `clone_mode` high set the low byte as in R2 and set `latch_q[15:8]` to 0x00.
- R4: A register-pair store to an absolute address sets `latch_q` to (address+1) modulo 65536. This covers unprefixed 0x22, and 0x43, 0x53, 0x63 or 0x73 with prefix byte 0xED.
- R5: An unprefixed accumulator load from an absolute address (opcode 0x3A) sets `latch_q` to (address+1) modulo 65536.
- R6: No cycle without a strobe, and no retired instruction outside R2 to R5, changes `latch_q`. This includes other 0xED opcodes, other unprefixed opcodes and bit tests.
- R7: A bit test has prefix 0xCB and an opcode in 0x40 to 0x7F. For it, `bit_zero` becomes 1 exactly when operand bit (opcode>>3)&7 is 0.
- R8: For a bit test whose opcode bits [2:0] equal 6, or whose `retire_idx` is high, `bit_f5` and `bit_f3` become bits 5 and 3 of the latch high byte held before that instruction. Otherwise they become bits 5 and 3 of `retire_opnd`.
- R9: `len_err` is 1 in the cycle after the retire of a store whose `retire_tstates` differs from its required count, and 0 in every other cycle. The counts are 7 for 0x02 and 0x12, 13 for 0x32, 16 for 0x22 and 20 for the 0xED pair stores.
- R10: All outputs change only on the clock edge that samples the strobe. The three flag outputs hold their values across every retire that is not a bit test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| retire_vld | input | 1 | Single-cycle retire strobe |
| retire_pfx_vld | input | 1 | A prefix byte accompanies the opcode |
| retire_pfx | input | 8 | Prefix byte (0xED extended page, 0xCB bit page) |
| retire_op | input | 8 | Main opcode byte |
| retire_idx | input | 1 | Instruction is an index-register form |
| retire_addr | input | 16 | Effective memory address of the instruction |
| retire_acc | input | 8 | Accumulator value before the instruction's write |
| retire_opnd | input | 8 | Operand byte tested by a bit test |
| retire_tstates | input | 5 | Clock states the instruction took |
| clone_mode | input | 1 | Selects the clone variant for accumulator stores |
| latch_q | output | 16 | Tracked hidden address latch |
| bit_zero | output | 1 | Zero result of the last bit test |
| bit_f5 | output | 1 | Hidden flag bit 5 of the last bit test |
| bit_f3 | output | 1 | Hidden flag bit 3 of the last bit test |
| len_err | output | 1 | One-cycle pulse: the previous store had the wrong length |

## Verification
Every result of this block is due exactly one clock edge after the strobe. This holds for the latch, the three flags and the length pulse, because each passes through a single register stage. The bench raises the strobe on a falling edge and lets the following rising edge capture it. It drops the strobe and compares all outputs on the next falling edge, half a period after they change. Idle cycles between retires are checked at the same phase. They show that the latch and flags hold, and that the length pulse has already returned to zero one edge later. Reset release passes through two synchronizer stages, so the bench waits several cycles after releasing reset before the first retire.

// File: rtl/alt_pkg.sv
package alt_pkg;

  localparam int OP_W = 8;

  typedef enum logic [2:0] {
    CLS_NONE,
    CLS_ACC_ST_RP,
    CLS_ACC_ST_ABS,
    CLS_PAIR_ST_BASE,
    CLS_PAIR_ST_EXT,
    CLS_ACC_LD_ABS,
    CLS_BITTEST
  } instr_cls_e;

  localparam logic [OP_W-1:0] OPC_ST_A_BC  = 8'h02;
  localparam logic [OP_W-1:0] OPC_ST_A_DE  = 8'h12;
  localparam logic [OP_W-1:0] OPC_ST_A_ABS = 8'h32;
  localparam logic [OP_W-1:0] OPC_ST_HL    = 8'h22;
  localparam logic [OP_W-1:0] OPC_LD_A_ABS = 8'h3A;
  localparam logic [OP_W-1:0] PFX_EXT_PAGE = 8'hED;
  localparam logic [OP_W-1:0] PFX_BIT_PAGE = 8'hCB;

  localparam int LEN_ACC_ST_RP    = 7;
  localparam int LEN_ACC_ST_ABS   = 13;
  localparam int LEN_PAIR_ST_BASE = 16;
  localparam int LEN_PAIR_ST_EXT  = 20;

endpackage

// File: rtl/alt_rst_sync.sv
module alt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/alt_decode.sv
module alt_decode
  import alt_pkg::*;
#(
  parameter int TS_W = 5
) (
  input  logic            pfx_vld,
  input  logic [OP_W-1:0] pfx,
  input  logic [OP_W-1:0] op,
  output instr_cls_e      cls,
  output logic            len_chk,
  output logic [TS_W-1:0] len_req
);

  logic ext_pair;

  always_comb begin
    ext_pair = (op[7:6] == 2'b01) && (op[3:0] == 4'h3);
    cls = CLS_NONE;
    if (!pfx_vld) begin
      case (op)
        OPC_ST_A_BC, OPC_ST_A_DE: cls = CLS_ACC_ST_RP;
        OPC_ST_A_ABS:             cls = CLS_ACC_ST_ABS;
        OPC_ST_HL:                cls = CLS_PAIR_ST_BASE;
        OPC_LD_A_ABS:             cls = CLS_ACC_LD_ABS;
        default:                  cls = CLS_NONE;
      endcase
    end else if (pfx == PFX_EXT_PAGE) begin
      if (ext_pair) cls = CLS_PAIR_ST_EXT;
    end else if (pfx == PFX_BIT_PAGE) begin
      if (op[7:6] == 2'b01) cls = CLS_BITTEST;
    end
  end

  always_comb begin
    len_chk = 1'b1;
    len_req = '0;
    case (cls)
      CLS_ACC_ST_RP:    len_req = TS_W'(LEN_ACC_ST_RP);
      CLS_ACC_ST_ABS:   len_req = TS_W'(LEN_ACC_ST_ABS);
      CLS_PAIR_ST_BASE: len_req = TS_W'(LEN_PAIR_ST_BASE);
      CLS_PAIR_ST_EXT:  len_req = TS_W'(LEN_PAIR_ST_EXT);
      default:          len_chk = 1'b0;
    endcase
  end

endmodule

// File: rtl/alt_latch.sv
module alt_latch
  import alt_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              en,
  input  instr_cls_e        cls,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] acc,
  input  logic              clone,
  output logic [ADDR_W-1:0] latch_q
);

  logic [ADDR_W-1:0] latch_d;
  logic [ADDR_W-1:0] addr_inc;
  logic [DATA_W-1:0] lo_inc;
  logic              acc_store;

  always_comb begin
    addr_inc  = addr + 1'b1;
    lo_inc    = addr[DATA_W-1:0] + 1'b1;
    acc_store = (cls == CLS_ACC_ST_RP) || (cls == CLS_ACC_ST_ABS);
    latch_d   = latch_q;
    case (cls)
      CLS_ACC_ST_RP, CLS_ACC_ST_ABS:
        latch_d = {(clone ? {DATA_W{1'b0}} : acc), lo_inc};
      CLS_PAIR_ST_BASE, CLS_PAIR_ST_EXT, CLS_ACC_LD_ABS:
        latch_d = addr_inc;
      default:
        latch_d = latch_q;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)  latch_q <= '0;
    else if (en)  latch_q <= latch_d;
  end

  // R2
  acc_lo_wrap_chk: assert property (@(posedge clk) disable iff (!srst_n)
    en && acc_store |=> latch_q[DATA_W-1:0] == DATA_W'($past(addr[DATA_W-1:0]) + 1'b1));

  // R2
  acc_hi_copy_chk: assert property (@(posedge clk) disable iff (!srst_n)
    en && acc_store && !clone |=> latch_q[ADDR_W-1:DATA_W] == $past(acc));

  // R3
  clone_hi_zero_chk: assert property (@(posedge clk) disable iff (!srst_n)
    en && acc_store && clone |=> latch_q[ADDR_W-1:DATA_W] == '0);

  // R4
  pair_inc_chk: assert property (@(posedge clk) disable iff (!srst_n)
    en && ((cls == CLS_PAIR_ST_BASE) || (cls == CLS_PAIR_ST_EXT))
    |=> latch_q == ADDR_W'($past(addr) + 1'b1));

  // R5
  load_inc_chk: assert property (@(posedge clk) disable iff (!srst_n)
    en && (cls == CLS_ACC_LD_ABS) |=> latch_q == ADDR_W'($past(addr) + 1'b1));

  // R6
  latch_idle_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !en |=> $stable(latch_q));

  // R6
  latch_other_chk: assert property (@(posedge clk) disable iff (!srst_n)
    en && ((cls == CLS_NONE) || (cls == CLS_BITTEST)) |=> $stable(latch_q));

endmodule

// File: rtl/alt_bitflags.sv
module alt_bitflags
  import alt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              en,
  input  logic              is_bit,
  input  logic              idx,
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] opnd,
  input  logic [DATA_W-1:0] latch_hi,
  output logic              zero_q,
  output logic              f5_q,
  output logic              f3_q
);

  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] src;
  logic              zero_d;
  logic              f5_d;
  logic              f3_d;
  logic              upd;

  always_comb begin
    mask = '0;
    mask[op[5:3]] = 1'b1;
    src    = (idx || (op[2:0] == 3'd6)) ? latch_hi : opnd;
    zero_d = ((opnd & mask) == '0);
    f5_d   = src[5];
    f3_d   = src[3];
    upd    = en && is_bit;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      zero_q <= 1'b0;
      f5_q   <= 1'b0;
      f3_q   <= 1'b0;
    end else if (upd) begin
      zero_q <= zero_d;
      f5_q   <= f5_d;
      f3_q   <= f3_d;
    end
  end

  // R7
  bit_zero_chk: assert property (@(posedge clk) disable iff (!srst_n)
    en && is_bit |=> zero_q == !$past(opnd[op[5:3]]));

  // R8
  mem_src_chk: assert property (@(posedge clk) disable iff (!srst_n)
    en && is_bit && (idx || (op[2:0] == 3'd6))
    |=> (f5_q == $past(latch_hi[5])) && (f3_q == $past(latch_hi[3])));

  // R10
  flags_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !(en && is_bit) |=> $stable({zero_q, f5_q, f3_q}));

endmodule

// File: rtl/addr_latch_tracker.sv
module addr_latch_tracker
  import alt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TS_W   = 5,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire_vld,
  input  logic              retire_pfx_vld,
  input  logic [OP_W-1:0]   retire_pfx,
  input  logic [OP_W-1:0]   retire_op,
  input  logic              retire_idx,
  input  logic [ADDR_W-1:0] retire_addr,
  input  logic [DATA_W-1:0] retire_acc,
  input  logic [DATA_W-1:0] retire_opnd,
  input  logic [TS_W-1:0]   retire_tstates,
  input  logic              clone_mode,
  output logic [ADDR_W-1:0] latch_q,
  output logic              bit_zero,
  output logic              bit_f5,
  output logic              bit_f3,
  output logic              len_err
);

  logic            srst_n;
  instr_cls_e      cls;
  logic            len_chk;
  logic [TS_W-1:0] len_req;
  logic            len_err_d;

  alt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  alt_decode #(.TS_W(TS_W)) u_dec (
    .pfx_vld (retire_pfx_vld),
    .pfx     (retire_pfx),
    .op      (retire_op),
    .cls     (cls),
    .len_chk (len_chk),
    .len_req (len_req)
  );

  alt_latch #(.DATA_W(DATA_W)) u_latch (
    .clk     (clk),
    .srst_n  (srst_n),
    .en      (retire_vld),
    .cls     (cls),
    .addr    (retire_addr),
    .acc     (retire_acc),
    .clone   (clone_mode),
    .latch_q (latch_q)
  );

  alt_bitflags #(.DATA_W(DATA_W)) u_flags (
    .clk      (clk),
    .srst_n   (srst_n),
    .en       (retire_vld),
    .is_bit   (cls == CLS_BITTEST),
    .idx      (retire_idx),
    .op       (retire_op),
    .opnd     (retire_opnd),
    .latch_hi (latch_q[ADDR_W-1:DATA_W]),
    .zero_q   (bit_zero),
    .f5_q     (bit_f5),
    .f3_q     (bit_f3)
  );

  always_comb begin
    len_err_d = retire_vld && len_chk && (retire_tstates != len_req);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) len_err <= 1'b0;
    else         len_err <= len_err_d;
  end

  // R9
  len_quiet_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !retire_vld |=> !len_err);

  // R9
  len_ok_chk: assert property (@(posedge clk) disable iff (!srst_n)
    retire_vld && !retire_pfx_vld && (retire_op == OPC_ST_A_ABS)
    && (retire_tstates == TS_W'(LEN_ACC_ST_ABS)) |=> !len_err);

endmodule

// File: tb/addr_latch_tracker_test.sv
`timescale 1ns/1ps
module addr_latch_tracker_test;

  logic        clk;
  logic        rst_n;
  logic        retire_vld;
  logic        retire_pfx_vld;
  logic [7:0]  retire_pfx;
  logic [7:0]  retire_op;
  logic        retire_idx;
  logic [15:0] retire_addr;
  logic [7:0]  retire_acc;
  logic [7:0]  retire_opnd;
  logic [4:0]  retire_tstates;
  logic        clone_mode;
  logic [15:0] latch_q;
  logic        bit_zero;
  logic        bit_f5;
  logic        bit_f3;
  logic        len_err;

  int n_chk;
  int n_fail;

  logic [15:0] m_latch;
  logic        m_zero;
  logic        m_f5;
  logic        m_f3;

  addr_latch_tracker uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .retire_vld     (retire_vld),
    .retire_pfx_vld (retire_pfx_vld),
    .retire_pfx     (retire_pfx),
    .retire_op      (retire_op),
    .retire_idx     (retire_idx),
    .retire_addr    (retire_addr),
    .retire_acc     (retire_acc),
    .retire_opnd    (retire_opnd),
    .retire_tstates (retire_tstates),
    .clone_mode     (clone_mode),
    .latch_q        (latch_q),
    .bit_zero       (bit_zero),
    .bit_f5         (bit_f5),
    .bit_f3         (bit_f3),
    .len_err        (len_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int req_len(input logic pv, input logic [7:0] p, input logic [7:0] op);
    if (!pv && (op == 8'h02 || op == 8'h12)) return 7;
    if (!pv && op == 8'h32) return 13;
    if (!pv && op == 8'h22) return 16;
    if (pv && p == 8'hED && (op == 8'h43 || op == 8'h53 || op == 8'h63 || op == 8'h73)) return 20;
    return -1;
  endfunction

  task automatic retire(input logic pv, input logic [7:0] p, input logic [7:0] op,
                        input logic idx, input logic [15:0] addr, input logic [7:0] acc,
                        input logic [7:0] opnd, input logic [4:0] ts, input logic cl);
    logic accst, pair, ld, bt, e_len;
    logic [7:0] src;
    int rl;
    string rq;
    accst = !pv && (op == 8'h02 || op == 8'h12 || op == 8'h32);
    pair  = (req_len(pv, p, op) == 16) || (req_len(pv, p, op) == 20);
    ld    = !pv && op == 8'h3A;
    bt    = pv && p == 8'hCB && op >= 8'h40 && op <= 8'h7F;
    rl    = req_len(pv, p, op);
    e_len = (rl >= 0) && (int'(ts) != rl);
    if (bt) begin
      m_zero = (opnd[op[5:3]] == 1'b0);
      src    = (idx || op[2:0] == 3'd6) ? m_latch[15:8] : opnd;
      m_f5   = src[5];
      m_f3   = src[3];
    end
    if (accst) begin
      m_latch[7:0]  = addr[7:0] + 8'd1;
      m_latch[15:8] = cl ? 8'h00 : acc;
      rq = cl ? "R3" : "R2";
    end else if (pair) begin
      m_latch = addr + 16'd1;
      rq = "R4";
    end else if (ld) begin
      m_latch = addr + 16'd1;
      rq = "R5";
    end else begin
      rq = "R6";
    end
    @(negedge clk);
    retire_vld = 1'b1; retire_pfx_vld = pv; retire_pfx = p; retire_op = op;
    retire_idx = idx; retire_addr = addr; retire_acc = acc; retire_opnd = opnd;
    retire_tstates = ts; clone_mode = cl;
    @(negedge clk);
    retire_vld = 1'b0;
    check(rq, latch_q, m_latch);
    check(bt ? "R7" : "R10", {15'd0, bit_zero}, {15'd0, m_zero});
    check(bt ? "R8" : "R10", {14'd0, bit_f5, bit_f3}, {14'd0, m_f5, m_f3});
    check("R9", {15'd0, len_err}, {15'd0, e_len});
  endtask

  task automatic idle_check();
    @(negedge clk);
    check("R6", latch_q, m_latch);
    check("R9", {15'd0, len_err}, 16'd0);
    check("R10", {13'd0, bit_zero, bit_f5, bit_f3}, {13'd0, m_zero, m_f5, m_f3});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] op;
    logic pv;
    logic [7:0] p;
    logic [4:0] ts;
    int rl;
    n_chk = 0; n_fail = 0;
    m_latch = 16'h0000; m_zero = 1'b0; m_f5 = 1'b0; m_f3 = 1'b0;
    retire_vld = 1'b0; retire_pfx_vld = 1'b0; retire_pfx = 8'h00; retire_op = 8'h00;
    retire_idx = 1'b0; retire_addr = 16'h0000; retire_acc = 8'h00; retire_opnd = 8'h00;
    retire_tstates = 5'd0; clone_mode = 1'b0;
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", latch_q, 16'h0000);
    check("R1", {12'd0, bit_zero, bit_f5, bit_f3, len_err}, 16'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", latch_q, 16'h0000);
    check("R1", {12'd0, bit_zero, bit_f5, bit_f3, len_err}, 16'd0);

    // R2 low byte wraps with no carry
    retire(1'b0, 8'h00, 8'h02, 1'b0, 16'h34FF, 8'h5A, 8'h00, 5'd7, 1'b0);
    idle_check();
    // R2 store via DE
    retire(1'b0, 8'h00, 8'h12, 1'b0, 16'h1280, 8'hC3, 8'h00, 5'd7, 1'b0);
    // R3 clone zeroes high byte
    retire(1'b0, 8'h00, 8'h32, 1'b0, 16'h12FF, 8'hA5, 8'h00, 5'd13, 1'b1);
    // R4 full wrap
    retire(1'b0, 8'h00, 8'h22, 1'b0, 16'hFFFF, 8'h00, 8'h00, 5'd16, 1'b0);
    retire(1'b1, 8'hED, 8'h73, 1'b0, 16'h1234, 8'h00, 8'h00, 5'd20, 1'b0);
    // R5 load wrap
    retire(1'b0, 8'h00, 8'h3A, 1'b0, 16'hFFFF, 8'h00, 8'h00, 5'd13, 1'b0);
    // R6 other ED opcode, non-bit CB opcode
    retire(1'b1, 8'hED, 8'h4B, 1'b0, 16'h7777, 8'h11, 8'h00, 5'd20, 1'b0);
    retire(1'b1, 8'hCB, 8'h06, 1'b0, 16'h7777, 8'h11, 8'h00, 5'd15, 1'b0);
    // R8 memory-form bit test reads latch high byte (0x28 has bits 5 and 3 set)
    retire(1'b0, 8'h00, 8'h02, 1'b0, 16'h0010, 8'h28, 8'h00, 5'd7, 1'b0);
    retire(1'b1, 8'hCB, 8'h46, 1'b0, 16'h0000, 8'h00, 8'h01, 5'd12, 1'b0);
    // R7/R8 register form, zero result
    retire(1'b1, 8'hCB, 8'h47, 1'b0, 16'h0000, 8'h00, 8'h00, 5'd8, 1'b0);
    // R8 index form with register encoding still reads latch
    retire(1'b1, 8'hCB, 8'h7F, 1'b1, 16'h0000, 8'h00, 8'h80, 5'd20, 1'b0);
    // R10 flags hold across non-bit retire
    retire(1'b0, 8'h00, 8'h22, 1'b0, 16'h0100, 8'h00, 8'hFF, 5'd16, 1'b0);
    // R9 wrong lengths, then pulse clears
    retire(1'b0, 8'h00, 8'h02, 1'b0, 16'h2000, 8'h01, 8'h00, 5'd8, 1'b0);
    idle_check();
    retire(1'b1, 8'hED, 8'h43, 1'b0, 16'h2000, 8'h01, 8'h00, 5'd19, 1'b0);
    retire(1'b0, 8'h00, 8'h32, 1'b0, 16'h2000, 8'h01, 8'h00, 5'd13, 1'b0);

    for (int i = 0; i < 400; i++) begin
      pv = 1'b0; p = 8'h00;
      case ($urandom % 8)
        0: op = 8'h02;
        1: op = 8'h12;
        2: op = 8'h32;
        3: op = 8'h22;
        4: begin pv = 1'b1; p = 8'hED; op = {2'b01, 2'($urandom), 4'h3}; end
        5: op = 8'h3A;
        6: begin pv = 1'b1; p = 8'hCB; op = {2'b01, 6'($urandom)}; end
        default: begin
          op = 8'($urandom);
          if ($urandom % 2 == 1) begin pv = 1'b1; p = ($urandom % 2 == 1) ? 8'hED : 8'hCB; end
        end
      endcase
      rl = req_len(pv, p, op);
      ts = (rl >= 0 && ($urandom % 5 != 0)) ? 5'(rl) : 5'($urandom);
      retire(pv, p, op, 1'($urandom), 16'($urandom), 8'($urandom), 8'($urandom), ts, 1'($urandom));
      if ($urandom % 4 == 0) idle_check();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule